// File: doc/BRIEF.md
# Two-Phase Global Checkpoint Coordinator

The coordinator drives a system-wide checkpoint across a fixed set of processor agents. A checkpoint begins in one of two ways. An interval timer can expire while the system runs normally, or a request can report that the undo log is close to overflow; the overflow request starts a checkpoint at once. The coordinator then sends a one-cycle checkpoint pulse to every agent. It gathers one completion reply from each agent and holds every agent stopped until the last reply is in. After that it sends a one-cycle resume pulse to all agents together.

Each commit flips a one-bit selector between the two log areas, so that the selector names the area that has just been finalised. In the same cycle the coordinator pulses a clear for the per-page "already logged" bits held elsewhere. The resume pulse follows one cycle later. The work the agents do internally is seen only as a reply that arrives after a variable delay.

Top module: `ckpt_coord`

## Requirements
- R1: While reset is held, and after it is released until the first checkpoint starts, `ckpt_o`, `resume_o` and `clr_logged_o` are 0 and `log_sel_o` is 0.
- R2: The checkpoint pulse `ckpt_o` is high for exactly one cycle. With no overflow request, the next checkpoint pulse comes exactly INTERVAL+1 cycles after a resume pulse, because the timer restarts at resume.
- R3: `resume_o` rises only after every agent has replied. If the last missing reply is sampled in cycle t, the commit cycle is t+1 and `resume_o` is high for one cycle in t+2.
- R4: Replies are sticky and are taken only while the coordinator is waiting for replies. Replies given before the checkpoint pulse, and a reply repeated or held by one agent, do not count for any other agent and cannot bring on resume.
- R5: An overflow request sampled while the coordinator is idle makes `ckpt_o` high in the next cycle.
- R6: An overflow request sampled during a checkpoint is remembered. A new checkpoint pulse follows two cycles after that checkpoint's resume pulse.
- R7: On every commit, `log_sel_o` toggles and `clr_logged_o` is high in the same single cycle, which lies directly before the resume cycle. `log_sel_o` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovf_req_i | input | 1 | Log-overflow request, sampled each cycle |
| done_i | input | N_AGENTS | Per-agent checkpoint-complete reply |
| ckpt_o | output | 1 | Broadcast checkpoint pulse |
| resume_o | output | 1 | Broadcast resume pulse |
| clr_logged_o | output | 1 | Clear pulse for per-page logged bits |
| log_sel_o | output | 1 | Selects the most recently finalised log area |

## Verification
The assertions take for granted that each agent raises `done_i` only in reply to a checkpoint pulse, and that `ovf_req_i` and `done_i` are synchronous to `clk`. The bench drives these inputs on falling edges so that each value is stable across the sampling edge. It raises a reply only after it has seen the checkpoint pulse and one further cycle has passed, except in the case where R4 deliberately drives replies outside the wait phase. There, stray and held replies are applied only in ways a correct coordinator must ignore, and they never complete the set of replies that resume depends on.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [2:0] {
    CK_IDLE   = 3'd0,
    CK_REQ    = 3'd1,
    CK_WAIT   = 3'd2,
    CK_COMMIT = 3'd3,
    CK_RESUME = 3'd4
  } ck_state_e;
endpackage

// File: rtl/ckpt_timer.sv
module ckpt_timer #(
  parameter int INTERVAL = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == LAST);
  assign cnt_en = restart || run;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || expire) cnt_d = '0;
    else if (run)          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: a restart leaves the count at zero
  assert_timer_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/ckpt_replies.sv
module ckpt_replies #(
  parameter int N_AGENTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                collect,
  input  logic [N_AGENTS-1:0] done_i,
  output logic                all_o,
  output logic [N_AGENTS-1:0] vec_o
);
  logic [N_AGENTS-1:0] vec_q, vec_d;
  logic                vec_en;

  assign vec_en = clear || collect;
  assign vec_d  = clear ? '0 : (vec_q | done_i);
  assign all_o  = collect && (&(vec_q | done_i));
  assign vec_o  = vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  // R4: while collecting, no collected reply is ever lost
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (collect && !clear) |=> ((vec_q & $past(vec_q)) == $past(vec_q)));
endmodule

// File: rtl/ckpt_fsm.sv
module ckpt_fsm
  import ckpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ovf_req_i,
  input  logic all_replied,
  output logic ckpt_o,
  output logic resume_o,
  output logic clr_logged_o,
  output logic log_sel_o,
  output logic collect,
  output logic clear,
  output logic timer_run,
  output logic timer_restart
);
  ck_state_e state_q, state_d;
  logic      pend_q, pend_d;
  logic      sel_q, sel_d;
  logic      is_idle, start, commit_now;

  assign is_idle    = (state_q == CK_IDLE);
  assign start      = is_idle && (expire || pend_q || ovf_req_i);
  assign commit_now = (state_q == CK_WAIT) && all_replied;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CK_IDLE:   if (start) state_d = CK_REQ;
      CK_REQ:    state_d = CK_WAIT;
      CK_WAIT:   if (all_replied) state_d = CK_COMMIT;
      CK_COMMIT: state_d = CK_RESUME;
      CK_RESUME: state_d = CK_IDLE;
      default:   state_d = CK_IDLE;
    endcase
  end

  assign pend_d = (pend_q || ovf_req_i) && !is_idle;
  assign sel_d  = sel_q ^ commit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CK_IDLE;
      pend_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (commit_now) sel_q <= sel_d;
    end
  end

  assign ckpt_o        = (state_q == CK_REQ);
  assign clear         = (state_q == CK_REQ);
  assign collect       = (state_q == CK_WAIT);
  assign clr_logged_o  = (state_q == CK_COMMIT);
  assign resume_o      = (state_q == CK_RESUME);
  assign log_sel_o     = sel_q;
  assign timer_run     = is_idle;
  assign timer_restart = (state_q == CK_RESUME);

  // R2: the checkpoint broadcast lasts one cycle
  assert_ckpt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |=> !ckpt_o);
  // R7: the clear pulse is followed directly by resume
  assert_clr_then_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_logged_o |=> resume_o);
  // R7: the selector changes only in the commit cycle
  assert_sel_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(log_sel_o) |-> clr_logged_o);
  // R5: an overflow request while idle starts a checkpoint next cycle
  assert_ovf_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && ovf_req_i) |=> ckpt_o);
  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ckpt_o, clr_logged_o, resume_o}));
endmodule

// File: rtl/ckpt_coord.sv
module ckpt_coord #(
  parameter int N_AGENTS = 4,
  parameter int INTERVAL = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ovf_req_i,
  input  logic [N_AGENTS-1:0] done_i,
  output logic                ckpt_o,
  output logic                resume_o,
  output logic                clr_logged_o,
  output logic                log_sel_o
);
  logic rst_meta_q, rst_sync_q;
  logic expire, all_replied, collect, clear, timer_run, timer_restart;
  logic [N_AGENTS-1:0] reply_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ckpt_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .run(timer_run),
    .restart(timer_restart), .expire(expire)
  );

  ckpt_replies #(.N_AGENTS(N_AGENTS)) u_replies (
    .clk(clk), .rst_n(rst_sync_q), .clear(clear), .collect(collect),
    .done_i(done_i), .all_o(all_replied), .vec_o(reply_vec)
  );

  ckpt_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_q), .expire(expire), .ovf_req_i(ovf_req_i),
    .all_replied(all_replied), .ckpt_o(ckpt_o), .resume_o(resume_o),
    .clr_logged_o(clr_logged_o), .log_sel_o(log_sel_o), .collect(collect),
    .clear(clear), .timer_run(timer_run), .timer_restart(timer_restart)
  );

  // R3: resume only with every agent's reply collected
  assert_resume_all_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    resume_o |-> (&reply_vec));
endmodule

// File: tb/ckpt_coord_bench.sv
module ckpt_coord_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IVL = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic ovf_req_i;
  logic [N-1:0] done_i;
  logic ckpt_o, resume_o, clr_logged_o, log_sel_o;

  int checks = 0;
  int errors = 0;
  logic exp_sel = 1'b0;

  ckpt_coord #(.N_AGENTS(N), .INTERVAL(IVL)) u_ckpt_coord (
    .clk(clk), .rst_n(rst_n), .ovf_req_i(ovf_req_i), .done_i(done_i),
    .ckpt_o(ckpt_o), .resume_o(resume_o), .clr_logged_o(clr_logged_o),
    .log_sel_o(log_sel_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges until ckpt_o is seen high
  task automatic wait_ckpt(output int n);
    n = 0;
    while (!ckpt_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // at the ckpt negedge: step into the wait phase, reply all, check commit/resume
  task automatic reply_all_and_commit(input string req);
    step(1);
    done_i = '1;
    step(1);
    done_i = '0;
    exp_sel = ~exp_sel;
    chk(clr_logged_o == 1'b1, "R7 clr pulse in commit", int'(clr_logged_o), 1);
    chk(log_sel_o == exp_sel, "R7 selector toggles with clr", int'(log_sel_o), int'(exp_sel));
    chk(resume_o == 1'b0, req, int'(resume_o), 0);
    step(1);
    chk(resume_o == 1'b1 && clr_logged_o == 1'b0, "R3 resume after commit", int'(resume_o), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ovf_req_i = 1'b0; done_i = '0;
    step(3);
    chk({ckpt_o, resume_o, clr_logged_o, log_sel_o} == 4'b0, "R1 outputs in reset",
        int'({ckpt_o, resume_o, clr_logged_o, log_sel_o}), 0);
    rst_n = 1'b1;
    step(5);
    chk({ckpt_o, resume_o, clr_logged_o, log_sel_o} == 4'b0, "R1 outputs after release",
        int'({ckpt_o, resume_o, clr_logged_o, log_sel_o}), 0);
  endtask

  task automatic t_first_staggered();
    int n;
    wait_ckpt(n);
    chk(ckpt_o == 1'b1, "R2 first periodic checkpoint", int'(ckpt_o), 1);
    step(1);
    chk(ckpt_o == 1'b0, "R2 checkpoint pulse width", int'(ckpt_o), 0);
    done_i = 4'b0100; step(1); done_i = '0; step(2);
    done_i = 4'b0001; step(1); done_i = '0; step(1);
    done_i = 4'b1000; step(1); done_i = '0;
    chk(resume_o == 1'b0 && clr_logged_o == 1'b0, "R3 no resume with agent 1 missing",
        int'(resume_o), 0);
    step(3);
    chk(resume_o == 1'b0, "R3 still waiting for agent 1", int'(resume_o), 0);
    done_i = 4'b0010; step(1); done_i = '0;
    exp_sel = ~exp_sel;
    chk(clr_logged_o == 1'b1 && log_sel_o == exp_sel, "R7 commit cycle after last reply",
        int'({clr_logged_o, log_sel_o}), int'({1'b1, exp_sel}));
    step(1);
    chk(resume_o == 1'b1, "R3 resume two cycles after last reply", int'(resume_o), 1);
  endtask

  task automatic t_interval();
    int n;
    wait_ckpt(n);
    chk(n == IVL + 1, "R2 timer restarts at resume", n, IVL + 1);
    reply_all_and_commit("R3 no early resume");
  endtask

  task automatic t_stray_and_held();
    int n;
    // stray replies while idle must not be kept
    step(2);
    done_i = '1; step(1); done_i = '0;
    wait_ckpt(n);
    chk(ckpt_o == 1'b1, "R4 periodic checkpoint after stray replies", int'(ckpt_o), 1);
    done_i = 4'b0001;
    step(8);
    chk(resume_o == 1'b0 && clr_logged_o == 1'b0, "R4 stray and held replies ignored",
        int'({resume_o, clr_logged_o}), 0);
    done_i = 4'b1111; step(1); done_i = '0;
    exp_sel = ~exp_sel;
    chk(clr_logged_o == 1'b1 && log_sel_o == exp_sel, "R4 commit once all reply",
        int'({clr_logged_o, log_sel_o}), int'({1'b1, exp_sel}));
    step(1);
    chk(resume_o == 1'b1, "R4 resume after full set", int'(resume_o), 1);
  endtask

  task automatic t_ovf_idle();
    step(5);
    ovf_req_i = 1'b1; step(1); ovf_req_i = 1'b0;
    chk(ckpt_o == 1'b1, "R5 overflow starts checkpoint next cycle", int'(ckpt_o), 1);
    reply_all_and_commit("R5 no early resume");
  endtask

  task automatic t_ovf_during();
    int n;
    step(3);
    ovf_req_i = 1'b1; step(1); ovf_req_i = 1'b0;
    chk(ckpt_o == 1'b1, "R5 overflow checkpoint", int'(ckpt_o), 1);
    step(2);
    ovf_req_i = 1'b1; step(1); ovf_req_i = 1'b0;
    done_i = '1; step(1); done_i = '0;
    exp_sel = ~exp_sel;
    chk(clr_logged_o == 1'b1 && log_sel_o == exp_sel, "R7 commit with pending overflow",
        int'({clr_logged_o, log_sel_o}), int'({1'b1, exp_sel}));
    step(1);
    chk(resume_o == 1'b1, "R6 resume", int'(resume_o), 1);
    step(1);
    chk(ckpt_o == 1'b0, "R6 idle cycle after resume", int'(ckpt_o), 0);
    step(1);
    chk(ckpt_o == 1'b1, "R6 remembered overflow restarts", int'(ckpt_o), 1);
    reply_all_and_commit("R6 no early resume");
    wait_ckpt(n);
    chk(n == IVL + 1, "R6 request consumed once", n, IVL + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_staggered();
    t_interval();
    t_stray_and_held();
    t_ovf_idle();
    t_ovf_during();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule